// File: doc/BRIEF.md
# Flash Image Fetch Sequencer

This block drives the copy of a contiguous boot image out of raw NAND flash into a destination memory. Software (or a boot ROM state machine) supplies a page-aligned start byte offset within the flash, the image length in bytes, the base address of the destination buffer and a flag for a 16-bit flash bus, then pulses `start`. The sequencer works out the first and last erase block and the first page, and visits each block in turn. Before it reads any block it asks a spare-area reader for the bad-block marker of that block. A block whose marker is not erased is skipped and the end bound moves out by one block, so the image lands on the next good blocks.

For each good block the sequencer asks a page-read engine for every page from the current page index to the last page of the block, and hands it a destination address that grows by one page per page read. Only the first block can start part-way through; every later block starts at page zero. Moving bytes and correcting them with ECC belong to the neighbouring engines. This block only does the sequencing and the address arithmetic. Page size, pages per block and the marker column are parameters given as powers of two, so every division is a shift.

Top module: `flash_image_fetch`

## Requirements
- R1: After reset `busy`, `done`, `mark_req` and `page_req` are low and `skip_count` is 0.
- R2: A `start` with `image_size` equal to 0 raises `done` for exactly one cycle, one cycle after the start edge, and issues no marker or page request.
- R3: The first block visited is `start_offset >> (PAGE_SHIFT+PPB_SHIFT)`, the first page is bits `[PAGE_SHIFT+PPB_SHIFT-1:PAGE_SHIFT]` of the offset, and the last block before any skip is `(start_offset+image_size-1) >> (PAGE_SHIFT+PPB_SHIFT)`.
- R4: Every visited block gets exactly one marker request on `mark_block` before any of its pages is requested. `mark_col` is `MARK_COL` on an 8-bit bus and `MARK_COL>>1` on a 16-bit bus.
- R5: On an 8-bit bus a block is good when `mark_data[7:0]` is 8'hFF. Bits [15:8] are ignored.
- R6: On a 16-bit bus a block is good only when `mark_data` is 16'hFFFF.
- R7: A good block gets page requests for page indexes from the current page up to `2**PPB_SHIFT-1`, in ascending order. Blocks after the first start at page 0.
- R8: The first page request carries `dest_base` on `page_dest`. Each accepted page adds `2**PAGE_SHIFT` bytes to it.
- R9: A bad block gets no page request. It raises the last-block bound by one and increments `skip_count`.
- R10: A request holds its fields stable until it is acknowledged. `mark_req` and `page_req` are never high together. `done` pulses one cycle after the final page of the last block is acknowledged, and `busy` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start a fetch (sampled when idle) |
| start_offset | input | ADDR_W | Page-aligned flash byte offset of the image |
| image_size | input | ADDR_W | Image length in bytes |
| dest_base | input | ADDR_W | Destination address of the first page |
| wide16 | input | 1 | 1 = 16-bit flash bus, 0 = 8-bit |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | One-cycle completion pulse |
| skip_count | output | BLK_W | Bad blocks skipped in the current or last fetch |
| mark_req | output | 1 | Marker read request to the spare-area reader |
| mark_block | output | BLK_W | Block whose marker is wanted (page 0) |
| mark_col | output | COL_W | Spare-area column in bus units |
| mark_ack | input | 1 | Marker data valid, completes the request |
| mark_data | input | 16 | Marker byte (low half) or word |
| page_req | output | 1 | Page read request to the page-read engine |
| page_block | output | BLK_W | Block of the page |
| page_idx | output | PPB_SHIFT | Page index within the block |
| page_dest | output | ADDR_W | Destination address for the page |
| page_ack | input | 1 | Page read finished |

## Verification
Each request is answered by a bench responder two cycles after it first sees the request. The fields are compared against a queue of expected marker and page requests in the cycle the acknowledge goes out, so they are checked while the design has to hold them. `done` is due one cycle after the edge that accepts the last page acknowledge, or one cycle after the start edge for an empty image. The bench polls for it at falling edges, then checks `skip_count` and that both queues are empty. In the next cycle it checks that `done` has dropped and `busy` is low.

// File: rtl/fimg_pkg.sv
package fimg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MARK = 2'd1,
    ST_PAGE = 2'd2,
    ST_FIN  = 2'd3
  } ld_state_e;
endpackage

// File: rtl/fimg_rst_sync.sv
module fimg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/fimg_geom.sv
module fimg_geom #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 11,
  parameter int PPB_SHIFT  = 6,
  localparam int BLK_SHIFT = PAGE_SHIFT + PPB_SHIFT,
  localparam int BLK_W     = ADDR_W - BLK_SHIFT + 1
) (
  input  logic [ADDR_W-1:0]    offset,
  input  logic [ADDR_W-1:0]    size,
  output logic [BLK_W-1:0]     first_blk,
  output logic [BLK_W-1:0]     last_blk,
  output logic [PPB_SHIFT-1:0] first_page
);
  logic [ADDR_W:0] end_byte;

  always_comb begin
    end_byte   = {1'b0, offset} + {1'b0, size} - {{ADDR_W{1'b0}}, 1'b1};
    first_blk  = {1'b0, offset[ADDR_W-1:BLK_SHIFT]};
    last_blk   = end_byte[ADDR_W:BLK_SHIFT];
    first_page = offset[BLK_SHIFT-1:PAGE_SHIFT];
  end
endmodule

// File: rtl/fimg_mark_eval.sv
module fimg_mark_eval (
  input  logic        wide,
  input  logic [15:0] marker,
  output logic        good
);
  always_comb begin
    if (wide) good = (marker == 16'hFFFF);
    else      good = (marker[7:0] == 8'hFF);
  end
endmodule

// File: rtl/flash_image_fetch.sv
module flash_image_fetch
  import fimg_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 11,
  parameter int PPB_SHIFT  = 6,
  parameter int COL_W      = 12,
  parameter int MARK_COL   = 0,
  localparam int BLK_SHIFT = PAGE_SHIFT + PPB_SHIFT,
  localparam int BLK_W     = ADDR_W - BLK_SHIFT + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [ADDR_W-1:0]    start_offset,
  input  logic [ADDR_W-1:0]    image_size,
  input  logic [ADDR_W-1:0]    dest_base,
  input  logic                 wide16,
  output logic                 busy,
  output logic                 done,
  output logic [BLK_W-1:0]     skip_count,
  output logic                 mark_req,
  output logic [BLK_W-1:0]     mark_block,
  output logic [COL_W-1:0]     mark_col,
  input  logic                 mark_ack,
  input  logic [15:0]          mark_data,
  output logic                 page_req,
  output logic [BLK_W-1:0]     page_block,
  output logic [PPB_SHIFT-1:0] page_idx,
  output logic [ADDR_W-1:0]    page_dest,
  input  logic                 page_ack
);
  localparam logic [ADDR_W-1:0]    PAGE_BYTES = ADDR_W'(1) << PAGE_SHIFT;
  localparam logic [PPB_SHIFT-1:0] PAGE_LAST  = '1;
  localparam logic [BLK_W-1:0]     BLK_ONE    = BLK_W'(1);

  logic rst_core_n;

  ld_state_e             state_q, state_n;
  logic [BLK_W-1:0]      blk_q, blk_n;
  logic [BLK_W-1:0]      last_q, last_n;
  logic [PPB_SHIFT-1:0]  page_q, page_n;
  logic [ADDR_W-1:0]     dest_q, dest_n;
  logic [BLK_W-1:0]      skip_q, skip_n;
  logic                  w16_q, w16_n;

  logic [BLK_W-1:0]      g_first_blk;
  logic [BLK_W-1:0]      g_last_blk;
  logic [PPB_SHIFT-1:0]  g_first_page;
  logic                  blk_good;

  fimg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  fimg_geom #(
    .ADDR_W     (ADDR_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .PPB_SHIFT  (PPB_SHIFT)
  ) u_geom (
    .offset     (start_offset),
    .size       (image_size),
    .first_blk  (g_first_blk),
    .last_blk   (g_last_blk),
    .first_page (g_first_page)
  );

  fimg_mark_eval u_mark (
    .wide   (w16_q),
    .marker (mark_data),
    .good   (blk_good)
  );

  // next-state logic
  always_comb begin
    state_n = state_q;
    blk_n   = blk_q;
    last_n  = last_q;
    page_n  = page_q;
    dest_n  = dest_q;
    skip_n  = skip_q;
    w16_n   = w16_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          w16_n  = wide16;
          blk_n  = g_first_blk;
          last_n = g_last_blk;
          page_n = g_first_page;
          dest_n = dest_base;
          skip_n = '0;
          state_n = (image_size == '0) ? ST_FIN : ST_MARK;
        end
      end
      ST_MARK: begin
        if (mark_ack) begin
          if (blk_good) begin
            state_n = ST_PAGE;
          end else begin
            last_n = last_q + BLK_ONE;
            skip_n = skip_q + BLK_ONE;
            blk_n  = blk_q + BLK_ONE;
          end
        end
      end
      ST_PAGE: begin
        if (page_ack) begin
          dest_n = dest_q + PAGE_BYTES;
          if (page_q == PAGE_LAST) begin
            page_n  = '0;
            blk_n   = blk_q + BLK_ONE;
            state_n = (blk_q == last_q) ? ST_FIN : ST_MARK;
          end else begin
            page_n = page_q + 1'b1;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_IDLE;
      blk_q   <= '0;
      last_q  <= '0;
      page_q  <= '0;
      dest_q  <= '0;
      skip_q  <= '0;
      w16_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      blk_q   <= blk_n;
      last_q  <= last_n;
      page_q  <= page_n;
      dest_q  <= dest_n;
      skip_q  <= skip_n;
      w16_q   <= w16_n;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign done       = (state_q == ST_FIN);
  assign skip_count = skip_q;
  assign mark_req   = (state_q == ST_MARK);
  assign mark_block = blk_q;
  assign mark_col   = w16_q ? COL_W'(MARK_COL >> 1) : COL_W'(MARK_COL);
  assign page_req   = (state_q == ST_PAGE);
  assign page_block = blk_q;
  assign page_idx   = page_q;
  assign page_dest  = dest_q;
endmodule

// File: rtl/fimg_checker.sv
module fimg_checker #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 11,
  parameter int PPB_SHIFT  = 6,
  parameter int BLK_W      = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 busy,
  input logic                 done,
  input logic                 mark_req,
  input logic [BLK_W-1:0]     mark_block,
  input logic                 mark_ack,
  input logic                 page_req,
  input logic [BLK_W-1:0]     page_block,
  input logic [PPB_SHIFT-1:0] page_idx,
  input logic [ADDR_W-1:0]    page_dest,
  input logic                 page_ack
);
  // R10: the two request lines never overlap
  a_r10_req_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mark_req && page_req));

  // R10: a pending marker request keeps its block
  a_r10_mark_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_req && !mark_ack) |=> (mark_req && $stable(mark_block)));

  // R10: a pending page request keeps its fields
  a_r10_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (page_req && !page_ack) |=> (page_req && $stable(page_dest)
                                 && $stable(page_idx) && $stable(page_block)));

  // R8: the destination moves by one page per accepted page
  a_r8_dest_step: assert property (@(posedge clk) disable iff (!rst_n)
    (page_req && page_ack) |=>
      (page_dest == $past(page_dest) + (ADDR_W'(1) << PAGE_SHIFT)));

  // R10: done is a single pulse followed by idle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R2: no request while done is shown
  a_r2_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mark_req && !page_req));
endmodule

bind flash_image_fetch fimg_checker #(
  .ADDR_W     (ADDR_W),
  .PAGE_SHIFT (PAGE_SHIFT),
  .PPB_SHIFT  (PPB_SHIFT),
  .BLK_W      (BLK_W)
) u_fimg_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .mark_req   (mark_req),
  .mark_block (mark_block),
  .mark_ack   (mark_ack),
  .page_req   (page_req),
  .page_block (page_block),
  .page_idx   (page_idx),
  .page_dest  (page_dest),
  .page_ack   (page_ack)
);

// File: tb/flash_image_fetch_tb_top.sv
`timescale 1ns/1ps
module flash_image_fetch_tb_top;
  localparam int ADDR_W     = 20;
  localparam int PAGE_SHIFT = 9;
  localparam int PPB_SHIFT  = 2;
  localparam int COL_W      = 8;
  localparam int MARK_COL   = 6;
  localparam int BLK_SHIFT  = PAGE_SHIFT + PPB_SHIFT;
  localparam int BLK_W      = ADDR_W - BLK_SHIFT + 1;
  localparam int PPB        = 1 << PPB_SHIFT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] start_offset = '0;
  logic [ADDR_W-1:0] image_size = '0;
  logic [ADDR_W-1:0] dest_base = '0;
  logic wide16 = 1'b0;
  logic busy, done;
  logic [BLK_W-1:0] skip_count;
  logic mark_req;
  logic [BLK_W-1:0] mark_block;
  logic [COL_W-1:0] mark_col;
  logic mark_ack = 1'b0;
  logic [15:0] mark_data = '0;
  logic page_req;
  logic [BLK_W-1:0] page_block;
  logic [PPB_SHIFT-1:0] page_idx;
  logic [ADDR_W-1:0] page_dest;
  logic page_ack = 1'b0;

  always #2 clk = ~clk;

  flash_image_fetch #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .PPB_SHIFT(PPB_SHIFT),
    .COL_W(COL_W), .MARK_COL(MARK_COL)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_offset(start_offset),
    .image_size(image_size), .dest_base(dest_base), .wide16(wide16),
    .busy(busy), .done(done), .skip_count(skip_count),
    .mark_req(mark_req), .mark_block(mark_block), .mark_col(mark_col),
    .mark_ack(mark_ack), .mark_data(mark_data),
    .page_req(page_req), .page_block(page_block), .page_idx(page_idx),
    .page_dest(page_dest), .page_ack(page_ack)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic bad_map [64];
  logic cur_w16 = 1'b0;
  logic [COL_W-1:0] exp_col = '0;
  logic [BLK_W-1:0] mk_q [$];
  logic [BLK_W+PPB_SHIFT+ADDR_W-1:0] pg_q [$];
  int mark_seen = 0;
  int page_seen = 0;
  int mcnt = 0;
  int pcnt = 0;
  logic finished = 1'b0;

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // marker responder and monitor (R4 R5 R6)
  always @(negedge clk) begin
    if (mark_ack) begin
      mark_ack <= 1'b0;
    end else if (mark_req) begin
      if (mcnt == 1) begin
        mcnt <= 0;
        mark_seen++;
        if (mk_q.size() == 0) begin
          chk(1'b0, "R4 unexpected marker request", longint'(mark_block), 0);
        end else begin
          logic [BLK_W-1:0] e;
          e = mk_q.pop_front();
          chk(mark_block == e, "R4 marker block", longint'(mark_block), longint'(e));
          chk(mark_col == exp_col, "R4 marker column", longint'(mark_col), longint'(exp_col));
        end
        if (cur_w16) mark_data <= bad_map[mark_block[5:0]] ? 16'h00FF : 16'hFFFF;
        else         mark_data <= bad_map[mark_block[5:0]] ? 16'hFF3C : 16'h00FF;
        mark_ack <= 1'b1;
      end else begin
        mcnt <= mcnt + 1;
      end
    end
  end

  // page responder and monitor (R7 R8 R9)
  always @(negedge clk) begin
    if (page_ack) begin
      page_ack <= 1'b0;
    end else if (page_req) begin
      if (pcnt == 1) begin
        pcnt <= 0;
        page_seen++;
        if (pg_q.size() == 0) begin
          chk(1'b0, "R9 unexpected page request", longint'(page_block), 0);
        end else begin
          logic [BLK_W+PPB_SHIFT+ADDR_W-1:0] e, a;
          e = pg_q.pop_front();
          a = {page_block, page_idx, page_dest};
          chk(a == e, "R7 R8 page block/index/dest", longint'(a), longint'(e));
        end
        page_ack <= 1'b1;
      end else begin
        pcnt <= pcnt + 1;
      end
    end
  end

  // driver: builds the expected request lists from the requirements, then runs
  task automatic run_job(input logic [ADDR_W-1:0] off, input logic [ADDR_W-1:0] sz,
                         input logic [ADDR_W-1:0] base, input logic w16, input string tag);
    int blk, last, pg, skips, wait_n;
    logic [ADDR_W-1:0] d;
    skips = 0;
    mark_seen = 0;
    page_seen = 0;
    if (sz != 0) begin
      blk  = int'(off) >> BLK_SHIFT;                 // R3
      last = (int'(off) + int'(sz) - 1) >> BLK_SHIFT; // R3
      pg   = (int'(off) >> PAGE_SHIFT) % PPB;        // R3
      d    = base;
      while (blk <= last) begin
        mk_q.push_back(BLK_W'(blk));
        if (bad_map[blk]) begin
          last++;
          skips++;                                   // R9
        end else begin
          while (pg < PPB) begin
            pg_q.push_back({BLK_W'(blk), PPB_SHIFT'(pg), d});
            d = d + (ADDR_W'(1) << PAGE_SHIFT);
            pg++;
          end
          pg = 0;                                    // R7
        end
        blk++;
      end
    end
    cur_w16 = w16;
    exp_col = w16 ? COL_W'(MARK_COL >> 1) : COL_W'(MARK_COL);
    @(negedge clk);
    start_offset = off; image_size = sz; dest_base = base; wide16 = w16;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_n = 0;
    while (!done && wait_n < 2000) begin
      @(negedge clk);
      wait_n++;
    end
    chk(done == 1'b1, {tag, " R10 done seen"}, longint'(done), 1);
    chk(skip_count == BLK_W'(skips), {tag, " R9 skip count"}, longint'(skip_count), longint'(skips));
    chk(mk_q.size() == 0, {tag, " R4 markers left"}, longint'(mk_q.size()), 0);
    chk(pg_q.size() == 0, {tag, " R7 pages left"}, longint'(pg_q.size()), 0);
    @(negedge clk);
    chk(!done && !busy, {tag, " R10 idle after done"}, longint'({done, busy}), 0);
    mk_q.delete();
    pg_q.delete();
  endtask

  initial begin
    for (int i = 0; i < 64; i++) bad_map[i] = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !mark_req && !page_req && skip_count == '0,
        "R1 reset outputs", longint'({busy, done, mark_req, page_req}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done, "R1 idle after reset release", longint'({busy, done}), 0);

    // R2: empty image completes with no requests
    @(negedge clk);
    image_size = '0; start_offset = 20'h01000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R2 done one cycle after start", longint'(done), 1);
    chk(!mark_req && !page_req, "R2 no requests", longint'({mark_req, page_req}), 0);
    @(negedge clk);
    chk(!done && !busy, "R2 done single pulse", longint'({done, busy}), 0);
    chk(mark_seen == 0 && page_seen == 0, "R2 no flash access", longint'(mark_seen + page_seen), 0);

    // R3 R7 R8: mid-block start across three good blocks, 8-bit bus
    run_job(20'd3072, 20'd3172, 20'h80000, 1'b0, "R3 midblock");

    // R5 R9: 8-bit bus, two adjacent bad blocks
    bad_map[5] = 1'b1; bad_map[6] = 1'b1;
    run_job(20'd8192, 20'd4096, 20'h10000, 1'b0, "R5 two bad");

    // R6 R4: 16-bit bus, one bad block, word marker and halved column
    bad_map[9] = 1'b1;
    run_job(20'd17920, 20'd1024, 20'h20000, 1'b1, "R6 wide");

    // R3: one-byte image still fetches the whole block
    run_job(20'd24576, 20'd1, 20'h30000, 1'b0, "R3 one byte");

    chk(mark_seen == 1 && page_seen == PPB, "R7 one-byte job counts",
        longint'(mark_seen * 100 + page_seen), longint'(100 + PPB));

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule